// File: doc/BRIEF.md
# AC97 Codec Register Access Controller

The block lets a host processor reach the control registers of an external AC97 codec through a small 32-bit register file. The host writes a codec register index and, for a write, a 16-bit value. The controller then places exactly one command into the next AC-link output frame, in the tag, slot 1 and slot 2 fields. Status frames returned by the codec are captured. The received index and data land back in the host-visible registers, and sticky flags report each step of the exchange.

The AC-link side runs from the codec's bit clock. The controller samples that clock with its own system clock and acts on the detected edges. Output bits change after each rising bit-clock edge, and input bits are taken after each falling edge. Besides command traffic, the block drives the link's cold reset line. It forces SYNC high for a warm reset while the link is stopped, and it reports the codec-ready bit carried in every incoming tag. Audio sample slots are always sent as zeros.

The host works with the flags by polling. It arms a command, waits for the address-sent and data-sent flags, clears them by writing 0, and reads replies the same way through the status-address and status-data flags.

Top module: `ac97_cmd_ctrl`

## Requirements
- R1: After reset every register reads 0, `sync` and `sdata_out` are 0 and `ac_reset_n` is 1.
- R2: Offsets 0x28, 0x2C, 0x50 and 0x58 are full 32-bit read/write storage. The other registers keep only their defined bits: control 11, 10, 9 and 5; command address 19:12; command data 19:4; audio control 30, 29, 26, 24, 23, 22 and 21. All other bits and unmapped offsets read 0.
- R3: While control bit 11 is 1, `ac_reset_n` is low.
- R4: While control bit 10 is 1 and control bit 5 is 0, `sync` is high.
- R5: With control bit 5 set, each frame is 256 bit clocks long, and `sync` is high for the first 16 of them.
- R6: A write of the command address register (offset 0x20) with bit 19 = 0 sends one write frame. Its tag is 0xE000, slot 1 holds the index (command address bits 18:12) in bits 18:12 with bit 19 = 0, slot 2 holds the command data bits 19:4 in bits 19:4, and every bit after slot 2 is 0. Transmit status (0x54) then reads 0xC0000000: bit 31 means the address was sent and bit 30 means the data was sent.
- R7: A command address write with bit 19 = 1 sends a read frame with tag 0xC000, slot 1 bit 19 = 1 and slot 2 all zero. Only transmit status bit 31 sets.
- R8: No command slot is sent while audio control (0x60) bit 26 is 0. An armed command waits and goes out once bit 26 is set.
- R9: Each command address write produces exactly one command frame, and the frame after it carries a zero tag.
- R10: An incoming tag with bit 14 set stores slot 1 bits 18:12 into command address bits 18:12 and sets receive status (0x5C) bit 22. Tag bit 13 stores slot 2 bits 19:4 into command data bits 19:4 and sets bit 21. Without those tag bits, nothing changes.
- R11: Control bit 15 is read-only and follows bit 15 of the most recent incoming tag.
- R12: The status flags are cleared only by a host write of 0 to the bit, and a write of 1 never sets them. A clearing write takes priority over a hardware set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_we | input | 1 | Write strobe for one clock cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| bit_clk | input | 1 | AC-link bit clock from the codec |
| sdata_in | input | 1 | Serial status frames from the codec |
| sync | output | 1 | Frame sync to the codec |
| sdata_out | output | 1 | Serial command frames to the codec |
| ac_reset_n | output | 1 | Active-low codec reset |

## Verification
Some properties are checked on every cycle. A reset write pulls the reset pin low, and a stopped link with warm reset forces SYNC high. SYNC may only be high in the first 16 bit positions, and a stopped link keeps `sdata_out` quiet. A clearing write always wins over a hardware set, the data-sent flag never rises during a read command, and codec ready moves only on a received tag. Other behaviour can only be shown by the bench's scenarios, with a codec responder that samples and drives the serial lines. These cover the bit layout of write and read frames, the one-frame-per-arm rule, the gating by audio-control bit 26, the capture of returned index and data under each valid-bit combination, and the storage masks of every register.

// File: rtl/ac97_cmd_ctrl.sv
module ac97_cmd_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          bit_clk,
  input  logic          sdata_in,
  output logic          sync,
  output logic          sdata_out,
  output logic          ac_reset_n
);
  localparam logic [AW-1:0] OFS_CTL  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_CADR = AW'(8'h20);
  localparam logic [AW-1:0] OFS_CDAT = AW'(8'h24);
  localparam logic [AW-1:0] OFS_PCML = AW'(8'h28);
  localparam logic [AW-1:0] OFS_PCMR = AW'(8'h2C);
  localparam logic [AW-1:0] OFS_TIE  = AW'(8'h50);
  localparam logic [AW-1:0] OFS_TST  = AW'(8'h54);
  localparam logic [AW-1:0] OFS_RIE  = AW'(8'h58);
  localparam logic [AW-1:0] OFS_RST  = AW'(8'h5C);
  localparam logic [AW-1:0] OFS_ACR  = AW'(8'h60);
  localparam int HDR_BITS = 56;
  localparam logic [7:0] SLOT1_END = 8'd36;
  localparam logic [7:0] SLOT2_END = 8'd56;
  localparam logic [7:0] TAG_BITS  = 8'd16;

  logic [31:0] pcm_l, pcm_r, tx_ie, rx_ie;
  logic        ctl_cold, ctl_warm, ctl_b9, ctl_run, codec_rdy;
  logic [7:0]  cmd_adr;
  logic [15:0] cmd_dat;
  logic [6:0]  acr_bits;
  logic        tx_adr_done, tx_dat_done, rx_adr_rdy, rx_dat_rdy;
  logic        cmd_pend, cur_vld, cur_rd;
  logic [6:0]  cur_idx;
  logic [15:0] cur_dat;
  logic [7:0]  bit_cnt;
  logic        run_seen, sync_q, sdo_q;
  logic [2:0]  bc_s;
  logic [HDR_BITS-1:0] rx_sh;

  wire wr_ctl  = reg_we && reg_addr == OFS_CTL;
  wire wr_cadr = reg_we && reg_addr == OFS_CADR;
  wire wr_cdat = reg_we && reg_addr == OFS_CDAT;
  wire wr_tst  = reg_we && reg_addr == OFS_TST;
  wire wr_rst  = reg_we && reg_addr == OFS_RST;
  wire wr_acr  = reg_we && reg_addr == OFS_ACR;

  wire bc_rise = bc_s[1] & ~bc_s[2];
  wire bc_fall = ~bc_s[1] & bc_s[2];
  wire tx_en   = acr_bits[4];
  wire frame_end = ctl_run && bc_rise && bit_cnt == 8'd255;

  wire [7:0] rx_idx = bit_cnt - 8'd1;
  wire rx_take = bc_fall && ctl_run && run_seen && rx_idx < 8'(HDR_BITS);
  wire [HDR_BITS-1:0] rx_word = {rx_sh[HDR_BITS-2:0], sdata_in};
  wire rx_done = rx_take && rx_idx == 8'(HDR_BITS - 1);
  wire [15:0] rx_tag = rx_word[55:40];
  wire set_rx_adr = rx_done & rx_tag[14];
  wire set_rx_dat = rx_done & rx_tag[13];
  logic rx_unused;
  assign rx_unused = ^{rx_tag[12:0], rx_word[39], rx_word[31:20], rx_word[3:0]};

  wire set_tx_adr = ctl_run && bc_rise && cur_vld && bit_cnt == SLOT1_END;
  wire set_tx_dat = ctl_run && bc_rise && cur_vld && !cur_rd && bit_cnt == SLOT2_END;

  wire [HDR_BITS-1:0] hdr = {cur_vld, cur_vld, cur_vld & ~cur_rd, 13'd0,
                             cur_rd, cur_idx, 12'd0,
                             cur_rd ? 16'd0 : cur_dat, 4'd0};
  wire tx_bit = (bit_cnt < 8'(HDR_BITS)) ? hdr[6'(8'd55 - bit_cnt)] : 1'b0;

  assign sync       = sync_q | (ctl_warm & ~ctl_run);
  assign sdata_out  = sdo_q;
  assign ac_reset_n = ~ctl_cold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc_s <= '0;
    else        bc_s <= {bc_s[1:0], bit_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_l <= '0; pcm_r <= '0; tx_ie <= '0; rx_ie <= '0;
      {ctl_cold, ctl_warm, ctl_b9, ctl_run} <= '0;
      acr_bits <= '0;
    end else begin
      if (reg_we && reg_addr == OFS_PCML) pcm_l <= reg_wdata;
      if (reg_we && reg_addr == OFS_PCMR) pcm_r <= reg_wdata;
      if (reg_we && reg_addr == OFS_TIE)  tx_ie <= reg_wdata;
      if (reg_we && reg_addr == OFS_RIE)  rx_ie <= reg_wdata;
      if (wr_ctl)
        {ctl_cold, ctl_warm, ctl_b9, ctl_run} <=
          {reg_wdata[11], reg_wdata[10], reg_wdata[9], reg_wdata[5]};
      if (wr_acr)
        acr_bits <= {reg_wdata[30], reg_wdata[29], reg_wdata[26], reg_wdata[24],
                     reg_wdata[23], reg_wdata[22], reg_wdata[21]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_adr <= '0; cmd_dat <= '0;
    end else begin
      if (wr_cadr)         cmd_adr <= reg_wdata[19:12];
      else if (set_rx_adr) cmd_adr[6:0] <= rx_word[38:32];
      if (wr_cdat)         cmd_dat <= reg_wdata[19:4];
      else if (set_rx_dat) cmd_dat <= rx_word[19:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_adr_done <= 1'b0; tx_dat_done <= 1'b0;
      rx_adr_rdy  <= 1'b0; rx_dat_rdy  <= 1'b0;
      codec_rdy   <= 1'b0;
    end else begin
      tx_adr_done <= (tx_adr_done | set_tx_adr) & ~(wr_tst & ~reg_wdata[31]);
      tx_dat_done <= (tx_dat_done | set_tx_dat) & ~(wr_tst & ~reg_wdata[30]);
      rx_adr_rdy  <= (rx_adr_rdy  | set_rx_adr) & ~(wr_rst & ~reg_wdata[22]);
      rx_dat_rdy  <= (rx_dat_rdy  | set_rx_dat) & ~(wr_rst & ~reg_wdata[21]);
      if (ctl_cold)     codec_rdy <= 1'b0;
      else if (rx_done) codec_rdy <= rx_tag[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_pend <= 1'b0;
    else        cmd_pend <= wr_cadr | (cmd_pend & ~(frame_end & tx_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; run_seen <= 1'b0; sync_q <= 1'b0; sdo_q <= 1'b0;
      cur_vld <= 1'b0; cur_rd <= 1'b0; cur_idx <= '0; cur_dat <= '0;
      rx_sh <= '0;
    end else if (!ctl_run) begin
      bit_cnt <= '0; run_seen <= 1'b0; sync_q <= 1'b0; sdo_q <= 1'b0;
      cur_vld <= 1'b0;
    end else begin
      if (bc_rise) begin
        run_seen <= 1'b1;
        sync_q   <= bit_cnt < TAG_BITS;
        sdo_q    <= tx_bit;
        bit_cnt  <= bit_cnt + 8'd1;
        if (bit_cnt == 8'd255) begin
          cur_vld <= cmd_pend & tx_en;
          cur_rd  <= cmd_adr[7];
          cur_idx <= cmd_adr[6:0];
          cur_dat <= cmd_dat;
        end
      end
      if (rx_take) rx_sh <= rx_word;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTL:  reg_rdata = {16'd0, codec_rdy, 3'd0, ctl_cold, ctl_warm, ctl_b9,
                             3'd0, ctl_run, 5'd0};
      OFS_CADR: reg_rdata = {12'd0, cmd_adr, 12'd0};
      OFS_CDAT: reg_rdata = {12'd0, cmd_dat, 4'd0};
      OFS_PCML: reg_rdata = pcm_l;
      OFS_PCMR: reg_rdata = pcm_r;
      OFS_TIE:  reg_rdata = tx_ie;
      OFS_TST:  reg_rdata = {tx_adr_done, tx_dat_done, 30'd0};
      OFS_RIE:  reg_rdata = rx_ie;
      OFS_RST:  reg_rdata = {9'd0, rx_adr_rdy, rx_dat_rdy, 21'd0};
      OFS_ACR:  reg_rdata = {1'b0, acr_bits[6], acr_bits[5], 2'b00, acr_bits[4], 1'b0,
                             acr_bits[3], acr_bits[2], acr_bits[1], acr_bits[0], 21'd0};
      default:  reg_rdata = 32'd0;
    endcase
  end
endmodule

module ac97_cmd_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [31:0]   reg_wdata,
  input logic          ctl_run,
  input logic          ac_reset_n,
  input logic          sync,
  input logic          sdata_out,
  input logic          sync_q,
  input logic [7:0]    bit_cnt,
  input logic          tx_adr_done,
  input logic          tx_dat_done,
  input logic          rx_adr_rdy,
  input logic          cur_rd,
  input logic          rx_done,
  input logic          ctl_cold,
  input logic          codec_rdy
);
  localparam logic [AW-1:0] A_CTL = AW'(8'h08);
  localparam logic [AW-1:0] A_TST = AW'(8'h54);
  localparam logic [AW-1:0] A_RST = AW'(8'h5C);

  AST_COLD_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTL && reg_wdata[11]) |=> !ac_reset_n); // R3
  AST_WARM_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTL && reg_wdata[10] && !reg_wdata[5]) |=> sync); // R4
  AST_SYNC_TAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (bit_cnt >= 8'd1 && bit_cnt <= 8'd16)); // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_run |=> !sdata_out); // R1
  AST_DATA_FLAG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_dat_done) |-> !cur_rd); // R7
  AST_TX_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_TST && !reg_wdata[31]) |=> !tx_adr_done); // R12
  AST_RX_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_RST && !reg_wdata[22]) |=> !rx_adr_rdy); // R12
  AST_READY_FROM_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && !ctl_cold) |=> $stable(codec_rdy)); // R11
endmodule

bind ac97_cmd_ctrl ac97_cmd_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .ctl_run(ctl_run), .ac_reset_n(ac_reset_n),
  .sync(sync), .sdata_out(sdata_out), .sync_q(sync_q), .bit_cnt(bit_cnt),
  .tx_adr_done(tx_adr_done), .tx_dat_done(tx_dat_done),
  .rx_adr_rdy(rx_adr_rdy), .cur_rd(cur_rd), .rx_done(rx_done),
  .ctl_cold(ctl_cold), .codec_rdy(codec_rdy)
);

// File: tb/test_ac97_cmd_ctrl.sv
module test_ac97_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bit_clk = 1'b0;
  logic        sdata_in = 1'b0;
  logic        sync, sdata_out, ac_reset_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  ac97_cmd_ctrl i_ac97_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_clk(bit_clk),
    .sdata_in(sdata_in), .sync(sync), .sdata_out(sdata_out),
    .ac_reset_n(ac_reset_n)
  );

  always #10 clk = ~clk;
  initial begin
    #7;
    forever #100 bit_clk = ~bit_clk;
  end

  // codec responder
  logic [7:0]   c_idx = 8'd0;
  logic         c_psync = 1'b0;
  int           c_cnt = 0, c_hi = 0, c_last_len = 0, c_last_hi = 0;
  logic [55:0]  c_cap = '0, c_frame = '0, resp = '0;
  logic         c_tail_nz = 1'b0, c_tail_last = 1'b0;
  int           c_frames = 0;

  always @(negedge bit_clk) begin
    if (sync && !c_psync) begin
      c_last_len = c_cnt; c_last_hi = c_hi;
      c_idx = 8'd0; c_cnt = 1; c_hi = 1; c_tail_nz = 1'b0;
    end else begin
      c_idx = c_idx + 8'd1; c_cnt++;
      if (sync) c_hi++;
    end
    c_psync = sync;
    if (c_idx < 8'd56) c_cap[6'(8'd55 - c_idx)] = sdata_out;
    else if (sdata_out) c_tail_nz = 1'b1;
    if (c_idx == 8'd55) begin c_frame = c_cap; c_frames++; end
    if (c_idx == 8'd255) c_tail_last = c_tail_nz;
  end

  always @(posedge bit_clk) begin
    logic [7:0] n;
    n = c_idx + 8'd1;
    sdata_in = (n < 8'd56) ? resp[6'(8'd55 - n)] : 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < n; i++) begin
      int f0;
      f0 = c_frames;
      wait (c_frames != f0);
    end
    @(negedge clk);
  endtask

  task automatic set_resp(input logic [55:0] v);
    wait_frames(1);
    resp = v;
  endtask

  task automatic send_cmd(input bit rdq, input logic [6:0] idx, input logic [15:0] dat);
    logic [31:0] v;
    logic [55:0] fr;
    bit got;
    wr(8'h24, {12'd0, dat, 4'd0});
    wr(8'h20, {12'd0, rdq, idx, 12'd0});
    got = 0;
    fr = '0;
    for (int i = 0; i < 4 && !got; i++) begin
      wait_frames(1);
      if (c_frame[55]) begin got = 1; fr = c_frame; end
    end
    if (rdq) begin
      chk("R7 tag", {16'd0, fr[55:40]}, 32'h0000C000);
      chk("R7 slot1", {12'd0, fr[39:20]}, {12'd0, 1'b1, idx, 12'd0});
      chk("R7 slot2", {12'd0, fr[19:0]}, 32'd0);
    end else begin
      chk("R6 tag", {16'd0, fr[55:40]}, 32'h0000E000);
      chk("R6 slot1", {12'd0, fr[39:20]}, {12'd0, 1'b0, idx, 12'd0});
      chk("R6 slot2", {12'd0, fr[19:0]}, {12'd0, dat, 4'd0});
    end
    wait_frames(1);
    chk("R9 next frame tag empty", {16'd0, c_frame[55:40]}, 32'd0);
    chk("R6 bits after slot2 zero", {31'd0, c_tail_last}, 32'd0);
    rd(8'h54, v);
    if (rdq) chk("R7 tx status", v, 32'h80000000);
    else     chk("R6 tx status", v, 32'hC0000000);
    wr(8'h54, 32'd0);
    rd(8'h54, v);
    chk("R12 tx status cleared", v, 32'd0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] offs [10];
    logic [7:0] stor [4];
    offs = '{8'h08, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h60};
    stor = '{8'h28, 8'h2C, 8'h50, 8'h58};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (offs[i]) begin rd(offs[i], v); chk("R1 reg reset", v, 32'd0); end
    chk("R1 sync", {31'd0, sync}, 32'd0);
    chk("R1 sdata_out", {31'd0, sdata_out}, 32'd0);
    chk("R1 ac_reset_n", {31'd0, ac_reset_n}, 32'd1);

    // R2 walking ones over plain storage
    foreach (stor[k])
      for (int b = 0; b < 32; b++) begin
        wr(stor[k], 32'd1 << b);
        rd(stor[k], v);
        chk("R2 storage walk", v, 32'd1 << b);
      end
    wr(8'h20, 32'hFFFFFFFF); rd(8'h20, v); chk("R2 cmd addr mask", v, 32'h000FF000);
    wr(8'h24, 32'hFFFFFFFF); rd(8'h24, v); chk("R2 cmd data mask", v, 32'h000FFFF0);
    wr(8'h60, 32'hFFFFFFFF); rd(8'h60, v); chk("R2 audio ctl mask", v, 32'h65E00000);
    wr(8'h08, 32'hFFFFFFFF); rd(8'h08, v); chk("R2 control mask", v, 32'h00000E20);
    wr(8'h08, 32'd0);
    wr(8'h54, 32'hFFFFFFFF); rd(8'h54, v); chk("R12 tx status not set by sw", v, 32'd0);
    wr(8'h5C, 32'hFFFFFFFF); rd(8'h5C, v); chk("R12 rx status not set by sw", v, 32'd0);
    rd(8'h04, v); chk("R2 unmapped reads 0", v, 32'd0);
    wr(8'h60, 32'd0);

    // R3 cold reset
    wr(8'h08, 32'h00000800);
    chk("R3 reset pin low", {31'd0, ac_reset_n}, 32'd0);
    wr(8'h08, 32'd0);
    chk("R3 reset pin released", {31'd0, ac_reset_n}, 32'd1);

    // R4 warm reset
    wr(8'h08, 32'h00000400);
    chk("R4 sync forced high", {31'd0, sync}, 32'd1);
    wr(8'h08, 32'd0);
    chk("R4 sync released", {31'd0, sync}, 32'd0);

    // start link; flush the command armed by the mask test
    wr(8'h60, 32'h04000000);
    wr(8'h08, 32'h00000020);
    wait_frames(3);
    wr(8'h54, 32'd0);
    rd(8'h54, v); chk("R12 tx status cleared after flush", v, 32'd0);

    // R5 frame timing
    chk("R5 frame length", c_last_len, 32'd256);
    chk("R5 sync width", c_last_hi, 32'd16);

    // R6/R7/R9 command sweep
    send_cmd(1'b0, 7'h00, 16'hFFFF);
    send_cmd(1'b0, 7'h7F, 16'h0001);
    send_cmd(1'b0, 7'h2A, 16'hA55A);
    send_cmd(1'b0, 7'h55, 16'h8000);
    send_cmd(1'b1, 7'h7F, 16'h1234);
    send_cmd(1'b1, 7'h01, 16'hFFFF);

    // R8 gating by audio-control bit 26
    wr(8'h60, 32'd0);
    wr(8'h24, {12'd0, 16'h0F0F, 4'd0});
    wr(8'h20, {12'd0, 1'b0, 7'h11, 12'd0});
    for (int i = 0; i < 3; i++) begin
      wait_frames(1);
      chk("R8 no command while disabled", {16'd0, c_frame[55:40]}, 32'd0);
    end
    rd(8'h54, v); chk("R8 no tx flags while disabled", v, 32'd0);
    wr(8'h60, 32'h04000000);
    begin
      bit got;
      got = 0;
      for (int i = 0; i < 4 && !got; i++) begin
        wait_frames(1);
        if (c_frame[55]) begin
          got = 1;
          chk("R8 deferred command tag", {16'd0, c_frame[55:40]}, 32'h0000E000);
          chk("R8 deferred command slot1", {12'd0, c_frame[39:20]}, 32'h00011000);
        end
      end
      chk("R8 deferred command sent", {31'd0, got}, 32'd1);
    end
    wait_frames(1);
    rd(8'h54, v); chk("R8 tx flags after enable", v, 32'hC0000000);
    wr(8'h54, 32'd0);

    // R10 status capture
    set_resp({16'h6000, 1'b0, 7'h5A, 12'd0, 16'hBEEF, 4'd0});
    wait_frames(2);
    set_resp('0);
    rd(8'h5C, v); chk("R10 both status flags", v, 32'h00600000);
    rd(8'h20, v); chk("R10 index captured", v & 32'h0007F000, 32'h0005A000);
    rd(8'h24, v); chk("R10 data captured", v, 32'h000BEEF0);
    wr(8'h5C, 32'd0);
    rd(8'h5C, v); chk("R12 rx status cleared", v, 32'd0);

    set_resp({16'h4000, 1'b0, 7'h33, 12'd0, 16'h1234, 4'd0});
    wait_frames(2);
    set_resp('0);
    rd(8'h5C, v); chk("R10 address flag only", v, 32'h00400000);
    rd(8'h20, v); chk("R10 index slot1 only", v & 32'h0007F000, 32'h00033000);
    rd(8'h24, v); chk("R10 data unchanged", v, 32'h000BEEF0);
    wr(8'h5C, 32'd0);

    set_resp({16'h0000, 1'b0, 7'h44, 12'd0, 16'h5555, 4'd0});
    wait_frames(2);
    set_resp('0);
    rd(8'h5C, v); chk("R10 no flags without valid tag", v, 32'd0);
    rd(8'h20, v); chk("R10 index kept", v & 32'h0007F000, 32'h00033000);
    rd(8'h24, v); chk("R10 data kept", v, 32'h000BEEF0);

    // R11 codec ready
    set_resp({16'h8000, 40'd0});
    wait_frames(2);
    rd(8'h08, v); chk("R11 codec ready set", v, 32'h00008020);
    wr(8'h08, 32'h00008020);
    rd(8'h08, v); chk("R11 ready bit read-only", v, 32'h00008020);
    set_resp('0);
    wait_frames(2);
    rd(8'h08, v); chk("R11 codec ready clear", v, 32'h00000020);

    finish_up();
  end
endmodule